// File: doc/BRIEF.md
# DC-Only Block Reconstruction Adder

This block reconstructs a pixel block whose residual has only one non-zero coefficient, the DC term. It does not run a full inverse transform. It turns the signed DC coefficient into one offset and adds that offset to every prediction pixel, saturating each result to the pixel range. A block starts with a one-cycle start pulse that carries the DC value and a 2-bit shape code. The shape code sets both the scaling rule and the pixel count.

Prediction pixels enter in raster order on a valid/ready stream. Reconstructed pixels leave in the same order on a second valid/ready stream. A one-cycle done pulse follows the last output pixel. The next block may start in the cycle after the done pulse.

Top module: `dc_offset_recon`

## Requirements
- R1: Shape code 0 (4 columns, 4 rows): the offset is o = (17*t + 64) >> 7, where t = (17*dc + 4) >> 3.
- R2: Shape code 1 (4 columns, 8 rows): the offset is o = (12*t + 64) >> 7, where t = (17*dc + 4) >> 3.
- R3: Shape code 2 (8 columns, 4 rows): the offset is o = (17*t + 64) >> 7, where t = (3*dc + 1) >> 1.
- R4: Shape code 3 (8 columns, 8 rows): the offset is o = (3*t + 16) >> 5, where t = (3*dc + 1) >> 1.
- R5: Each output pixel equals the input pixel plus the offset, clamped to 255 when the sum is larger than 255.
- R6: Each output pixel equals the input pixel plus the offset, clamped to 0 when the sum is negative.
- R7: Each block has a fixed number of pixels: 16 for code 0, 32 for codes 1 and 2, and 64 for code 3. Bit 1 of the code selects 8 columns and bit 0 selects 8 rows. blk_done pulses for exactly one cycle, in the cycle after the last output pixel is transferred.
- R8: The DC input is a signed 12-bit value. Every right shift is arithmetic, so negative intermediate values round toward minus infinity.
- R9: While pix_out_valid is high and pix_out_ready is low, pix_out_valid stays high and pix_out_data stays unchanged. No input pixel is accepted during that time.
- R10: A blk_start pulse that arrives while a block is still in progress has no effect. Its DC value and shape code are ignored.
- R11: After reset, pix_out_valid, pix_in_ready and blk_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_start | input | 1 | Starts a block when the block is idle |
| blk_dc | input | 12 | Signed DC coefficient, sampled with blk_start |
| blk_shape | input | 2 | Shape code, sampled with blk_start |
| pix_in_valid | input | 1 | Prediction pixel valid |
| pix_in_data | input | 8 | Prediction pixel |
| pix_in_ready | output | 1 | Prediction pixel accepted when high together with valid |
| pix_out_valid | output | 1 | Reconstructed pixel valid |
| pix_out_data | output | 8 | Reconstructed pixel |
| pix_out_ready | input | 1 | Downstream accepts the reconstructed pixel |
| blk_done | output | 1 | One-cycle pulse after the last output pixel |

## Verification
A wrong latched offset shows up on the first output pixel of the block, one cycle after that pixel is accepted. Each shape and sign of DC is therefore compared pixel by pixel against an independent model.

A corrupted pixel counter shows up at the end of the block: the done pulse comes early or late relative to the count of transferred pixels, or a pixel is left over or missing. A start that is wrongly accepted mid-block changes the offset. The pixels that follow then stop matching, within a cycle of the stray pulse.

Backpressure bugs show as changed output data or a dropped valid during a stall. These are checked on every stalled cycle.

// File: rtl/dc_offset_recon.sv
module dc_offset_recon #(
  parameter int DC_W   = 12,
  parameter int PIX_W  = 8,
  parameter int PROD_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_start,
  input  logic [DC_W-1:0]  blk_dc,
  input  logic [1:0]       blk_shape,
  input  logic             pix_in_valid,
  input  logic [PIX_W-1:0] pix_in_data,
  output logic             pix_in_ready,
  output logic             pix_out_valid,
  output logic [PIX_W-1:0] pix_out_data,
  input  logic             pix_out_ready,
  output logic             blk_done
);
  localparam int MAX_PIX = 64;
  localparam int CNT_W   = $clog2(MAX_PIX) + 1;
  localparam logic signed [PROD_W-1:0] K1   = 1;
  localparam logic signed [PROD_W-1:0] K4   = 4;
  localparam logic signed [PROD_W-1:0] K64  = 64;
  localparam logic signed [PROD_W-1:0] PMAX = (1 << PIX_W) - 1;

  logic                     busy;
  logic signed [PROD_W-1:0] ofs;
  logic [CNT_W-1:0]         in_left, out_left;

  logic signed [PROD_W-1:0] dcx, s1, s2, pix_x, sum;
  logic [PIX_W-1:0]         pix_sat;
  logic [CNT_W-1:0]         npix;
  logic                     in_fire, out_fire;

  // stage 1 depends on width, stage 2 on height
  assign dcx = PROD_W'(signed'(blk_dc));
  assign s1  = blk_shape[1] ? (((dcx <<< 1) + dcx + K1) >>> 1)
                            : (((dcx <<< 4) + dcx + K4) >>> 3);
  assign s2  = blk_shape[0] ? (((s1 <<< 3) + (s1 <<< 2) + K64) >>> 7)
                            : (((s1 <<< 4) + s1 + K64) >>> 7);
  assign npix = CNT_W'(16) << ({1'b0, blk_shape[1]} + {1'b0, blk_shape[0]});

  assign pix_x = $signed({{(PROD_W-PIX_W){1'b0}}, pix_in_data});
  assign sum   = pix_x + ofs;

  always_comb begin
    if (sum < 0)         pix_sat = '0;
    else if (sum > PMAX) pix_sat = '1;
    else                 pix_sat = sum[PIX_W-1:0];
  end

  assign pix_in_ready = busy && (in_left != '0) && (!pix_out_valid || pix_out_ready);
  assign in_fire      = pix_in_valid && pix_in_ready;
  assign out_fire     = pix_out_valid && pix_out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy          <= 1'b0;
      ofs           <= '0;
      in_left       <= '0;
      out_left      <= '0;
      pix_out_valid <= 1'b0;
      pix_out_data  <= '0;
      blk_done      <= 1'b0;
    end else begin
      blk_done <= 1'b0;
      if (!busy && blk_start) begin
        busy     <= 1'b1;
        ofs      <= s2;
        in_left  <= npix;
        out_left <= npix;
      end
      if (in_fire) begin
        pix_out_valid <= 1'b1;
        pix_out_data  <= pix_sat;
        in_left       <= in_left - CNT_W'(1);
      end else if (out_fire) begin
        pix_out_valid <= 1'b0;
      end
      if (out_fire) begin
        out_left <= out_left - CNT_W'(1);
        if (out_left == CNT_W'(1)) begin
          busy     <= 1'b0;
          blk_done <= 1'b1;
        end
      end
    end
  end
endmodule

module dc_offset_recon_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             pix_in_ready,
  input logic             pix_out_valid,
  input logic             pix_out_ready,
  input logic [PIX_W-1:0] pix_out_data,
  input logic             blk_done
);
  a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_out_valid && !pix_out_ready) |=> pix_out_valid);
  a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_out_valid && !pix_out_ready) |=> $stable(pix_out_data));
  a_r9_no_take_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_out_valid && !pix_out_ready) |-> !pix_in_ready);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done);
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> (!busy && !pix_out_valid));
  a_r11_idle_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    pix_in_ready |-> busy);
endmodule

bind dc_offset_recon dc_offset_recon_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .pix_in_ready(pix_in_ready),
  .pix_out_valid(pix_out_valid), .pix_out_ready(pix_out_ready),
  .pix_out_data(pix_out_data), .blk_done(blk_done));

// File: tb/sim_dc_offset_recon.sv
module sim_dc_offset_recon;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       blk_start = 1'b0;
  logic [11:0] blk_dc = '0;
  logic [1:0] blk_shape = '0;
  logic       pix_in_valid = 1'b0;
  logic [7:0] pix_in_data = '0;
  logic       pix_in_ready;
  logic       pix_out_valid;
  logic [7:0] pix_out_data;
  logic       pix_out_ready = 1'b1;
  logic       blk_done;

  int checks = 0, fails = 0;
  int expq[$];
  int got_n = 0, exp_n = 0;
  bit stall_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  always #2 clk = ~clk;

  dc_offset_recon u0 (.*);

  function automatic int offset_of(int dc, int sh);
    int t;
    case (sh)
      0: begin t = (17*dc + 4) >>> 3; return (17*t + 64) >>> 7; end
      1: begin t = (17*dc + 4) >>> 3; return (12*t + 64) >>> 7; end
      2: begin t = (3*dc + 1) >>> 1;  return (17*t + 64) >>> 7; end
      default: begin t = (3*dc + 1) >>> 1; return (3*t + 16) >>> 5; end
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    pix_out_ready = stall_en ? lfsr[0] : 1'b1;
  end

  // monitor
  initial begin
    bit blocked = 1'b0;
    logic [7:0] held = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (blocked && pix_out_valid)
          check(pix_out_data == held, "R9 stall hold", pix_out_data, held);
        else if (blocked)
          check(1'b0, "R9 valid dropped", 0, 1);
        if (pix_out_valid && pix_out_ready) begin
          if (expq.size() == 0) check(1'b0, "R7 extra pixel", pix_out_data, -1);
          else begin
            int e;
            e = expq.pop_front();
            check(pix_out_data == e, "R1-6/R8/R10 pixel", pix_out_data, e);
          end
          got_n++;
        end
        if (blk_done) begin
          check(got_n == exp_n && expq.size() == 0, "R7 count at done", got_n, exp_n);
        end
        blocked = pix_out_valid && !pix_out_ready;
        held    = pix_out_data;
      end
    end
  end

  task automatic run_block(int dc, int sh, int base, int step, bit poke);
    int n, o;
    n = (sh[1] ? 8 : 4) * (sh[0] ? 8 : 4);
    o = offset_of(dc, sh);
    got_n = 0;
    exp_n = n;
    @(posedge clk); #1;
    blk_start = 1'b1; blk_dc = 12'(dc); blk_shape = 2'(sh);
    @(posedge clk); #1;
    blk_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      int p, r;
      @(posedge clk); #1;
      blk_start = poke && (i == 3);
      if (poke && i == 3) begin blk_dc = 12'(-dc); blk_shape = 2'(~sh); end
      p = (base + i*step) & 255;
      pix_in_valid = 1'b1; pix_in_data = 8'(p);
      do @(negedge clk); while (!pix_in_ready);
      r = p + o;
      if (r > 255) r = 255;
      if (r < 0) r = 0;
      expq.push_back(r);
    end
    @(posedge clk); #1;
    pix_in_valid = 1'b0; blk_start = 1'b0;
    do @(negedge clk); while (!blk_done);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!pix_out_valid && !pix_in_ready && !blk_done, "R11 reset state",
          {pix_out_valid, pix_in_ready, blk_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!pix_in_ready && !blk_done, "R11 idle after reset", pix_in_ready, 0);
    check(offset_of(100, 0) == 28, "R1 model", offset_of(100, 0), 28);
    run_block(100, 0, 10, 7, 0);      // R1
    run_block(-37, 1, 90, 3, 0);      // R2 R8
    run_block(500, 2, 180, 5, 0);     // R3 R5
    run_block(-2048, 3, 40, 11, 0);   // R4 R6
    run_block(-1, 0, 0, 1, 0);        // R8 rounding
    stall_en = 1'b1;
    run_block(2047, 3, 120, 13, 0);   // R4 R5 R9
    run_block(-300, 1, 30, 9, 1);     // R2 R6 R10
    run_block(777, 2, 200, 1, 1);     // R3 R10
    stall_en = 1'b0;
    run_block(33, 3, 7, 17, 0);       // R4
    repeat (4) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule